// File: doc/BRIEF.md
# Dual-Threshold Watchdog Timer

This block is a free-running watchdog counter that software must service through a two-step write sequence. It compares the count against two thresholds. The first threshold raises an interrupt. The second threshold asks the system for a reset. Each threshold is a power of two, chosen by its own 4-bit code. Each threshold has its own enable and its own sticky status flag.

Software reaches the block over a simple word-addressed register bus. Word 0 holds the configuration and status. Word 1 is the service register, which is write-only and reads as zero. Each time the counter is serviced it restarts from zero, and both timeouts are measured again from that point.

A parameter shortens every timeout exponent by a fixed amount, so that short timeouts can be exercised in simulation.

Top module: `wdog_dual`

## Requirements
- R1: After reset, word 0 reads as 0x00000000 (timer off, both enables off, both codes 0, both flags clear), `irq` is 0 and `rst_req` is 0.
- R2: The word 0 layout is fixed. Bits [3:0] are the interrupt code. Bits [7:4] are the reset code. Bit 8 is the timer enable. Bit 9 is the interrupt flag. Bit 10 is the interrupt enable. Bit 11 is the reset enable. Bit 31 is the reset flag. All other bits read 0.
- R3: A code n selects a timeout of 2^(31−n−SIM_SHIFT) clock edges. The interrupt flag sets on the edge at which that many enabled edges have passed since the last counter clear.
- R4: The reset timeout is decoded from its own code, independently of the interrupt timeout. When the reset enable is 1, reaching the reset timeout produces a `rst_req` pulse exactly one cycle long.
- R5: Two consecutive writes to word 1 clear the counter. The first write carries 0xA5 and the second carries 0x5A, both in bits [7:0]. The counter is cleared on the edge of the second write.
- R6: A write to word 1 of any value other than the expected one breaks the sequence. In that case the counter is not cleared, even if 0x5A follows.
- R7: While the timer enable is 0, the counter holds its value and no flag or output event occurs. When the timer is enabled again, counting resumes from the held value.
- R8: `irq` is the interrupt flag gated by the interrupt enable. With the enable at 0 the flag still sets, but `irq` stays 0.
- R9: With the reset enable at 0, the reset flag still sets, but no `rst_req` pulse is produced.
- R10: Both flags are sticky. Writing 1 to bit 9 or bit 31 of word 0 clears that flag. The reset flag stays set after the request it caused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Bus access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address: 0 = config/status, 1 = service |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed word |
| irq | output | 1 | Interrupt, level |
| rst_req | output | 1 | One-cycle reset request |

## Verification
The hardest case to reach from the ports is the timer-disable hold. It only means something if the count is frozen at a known non-zero value and then resumes from that value.

The stimulus gets there in three steps:
- It services the counter.
- It turns the timer off one edge later.
- After a long idle gap with no events, it re-enables the timer and expects both events one edge earlier than they would fall after a fresh clear.

A broken service sequence (0xA5, another value, then 0x5A) is placed just before the first threshold, so that a wrongly accepted clear would move both events.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int DATA_W = 32;
  localparam int CODE_W = 4;
  localparam int KEY_W  = 8;
  localparam int NCH    = 2;
  localparam int CH_IRQ = 0;
  localparam int CH_RST = 1;

  localparam logic [KEY_W-1:0] KEY_FIRST  = 8'hA5;
  localparam logic [KEY_W-1:0] KEY_SECOND = 8'h5A;

  localparam int WORD_CFG  = 0;
  localparam int WORD_FEED = 1;

  localparam int IRQ_CODE_LSB = 0;
  localparam int RST_CODE_LSB = 4;
  localparam int TMR_EN_BIT   = 8;
  localparam int IRQ_FLAG_BIT = 9;
  localparam int IRQ_EN_BIT   = 10;
  localparam int RST_EN_BIT   = 11;
  localparam int RST_FLAG_BIT = 31;

  typedef struct packed {
    logic              rst_en;
    logic              irq_en;
    logic              tmr_en;
    logic [CODE_W-1:0] rst_code;
    logic [CODE_W-1:0] irq_code;
  } cfg_t;
endpackage

// File: rtl/wdog_feed.sv
module wdog_feed
  import wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_stb,
  input  logic [KEY_W-1:0] key,
  output logic             clr
);
  logic armed_q, armed_d;

  always_comb begin
    armed_d = armed_q;
    clr     = 1'b0;
    if (wr_stb) begin
      if (key == KEY_FIRST) begin
        armed_d = 1'b1;
      end else begin
        clr     = armed_q && (key == KEY_SECOND);
        armed_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_d;
  end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
  import wdog_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int SHIFT = 0
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        en,
  input  logic                        clr,
  input  logic [NCH-1:0][CODE_W-1:0]  codes,
  output logic [NCH-1:0]              hit,
  output logic [CNT_W-1:0]            cnt
);
  localparam int MAX_EXP = CNT_W - 1 - SHIFT;
  localparam int SH_W    = $clog2(CNT_W) + 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)     cnt_d = '0;
    else if (en) cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_thr
    logic [SH_W-1:0]  exp_amt;
    logic [CNT_W-1:0] lim;
    always_comb begin
      exp_amt = SH_W'(MAX_EXP) - SH_W'(codes[ch]);
      lim     = (CNT_W'(1) << exp_amt) - CNT_W'(1);
      hit[ch] = en && (cnt_q == lim);
    end
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wdata,
  input  logic              hit_irq,
  input  logic              hit_rst,
  output cfg_t              cfg,
  output logic              irq_flag,
  output logic              rst_flag,
  output logic              rst_req
);
  cfg_t cfg_q, cfg_d;
  logic irq_flag_q, irq_flag_d;
  logic rst_flag_q, rst_flag_d;
  logic rst_req_q, rst_req_d;
  logic unused_wbits;

  assign unused_wbits = ^wdata[RST_FLAG_BIT-1:RST_EN_BIT+1];

  always_comb begin
    cfg_d = cfg_q;
    if (wr_stb) begin
      cfg_d.rst_en   = wdata[RST_EN_BIT];
      cfg_d.irq_en   = wdata[IRQ_EN_BIT];
      cfg_d.tmr_en   = wdata[TMR_EN_BIT];
      cfg_d.rst_code = wdata[RST_CODE_LSB +: CODE_W];
      cfg_d.irq_code = wdata[IRQ_CODE_LSB +: CODE_W];
    end

    irq_flag_d = irq_flag_q;
    if (wr_stb && wdata[IRQ_FLAG_BIT]) irq_flag_d = 1'b0;
    if (hit_irq)                       irq_flag_d = 1'b1;

    rst_flag_d = rst_flag_q;
    if (wr_stb && wdata[RST_FLAG_BIT]) rst_flag_d = 1'b0;
    if (hit_rst)                       rst_flag_d = 1'b1;

    rst_req_d = hit_rst && cfg_q.rst_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q      <= '0;
      irq_flag_q <= 1'b0;
      rst_flag_q <= 1'b0;
      rst_req_q  <= 1'b0;
    end else begin
      cfg_q      <= cfg_d;
      irq_flag_q <= irq_flag_d;
      rst_flag_q <= rst_flag_d;
      rst_req_q  <= rst_req_d;
    end
  end

  assign cfg      = cfg_q;
  assign irq_flag = irq_flag_q;
  assign rst_flag = rst_flag_q;
  assign rst_req  = rst_req_q;
endmodule

// File: rtl/wdog_dual.sv
module wdog_dual
  import wdog_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int SIM_SHIFT = 0,
  parameter int ADDR_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  output logic              rst_req
);
  cfg_t                      cfg;
  logic                      cfg_wr, feed_wr, feed_clr;
  logic                      irq_flag, rst_flag, tmr_en;
  logic [NCH-1:0]            hit;
  logic [NCH-1:0][CODE_W-1:0] codes;
  logic [CNT_W-1:0]          cnt;
  logic                      unused_cnt;

  assign cfg_wr  = bus_valid && bus_write && (bus_addr == ADDR_W'(WORD_CFG));
  assign feed_wr = bus_valid && bus_write && (bus_addr == ADDR_W'(WORD_FEED));
  assign tmr_en  = cfg.tmr_en;
  assign unused_cnt = ^cnt;

  always_comb begin
    codes         = '0;
    codes[CH_IRQ] = cfg.irq_code;
    codes[CH_RST] = cfg.rst_code;
  end

  wdog_feed u_feed (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_stb (feed_wr),
    .key    (bus_wdata[KEY_W-1:0]),
    .clr    (feed_clr)
  );

  wdog_counter #(.CNT_W(CNT_W), .SHIFT(SIM_SHIFT)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (tmr_en),
    .clr   (feed_clr),
    .codes (codes),
    .hit   (hit),
    .cnt   (cnt)
  );

  wdog_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_stb   (cfg_wr),
    .wdata    (bus_wdata),
    .hit_irq  (hit[CH_IRQ]),
    .hit_rst  (hit[CH_RST]),
    .cfg      (cfg),
    .irq_flag (irq_flag),
    .rst_flag (rst_flag),
    .rst_req  (rst_req)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(WORD_CFG)) begin
      bus_rdata[IRQ_CODE_LSB +: CODE_W] = cfg.irq_code;
      bus_rdata[RST_CODE_LSB +: CODE_W] = cfg.rst_code;
      bus_rdata[TMR_EN_BIT]   = cfg.tmr_en;
      bus_rdata[IRQ_FLAG_BIT] = irq_flag;
      bus_rdata[IRQ_EN_BIT]   = cfg.irq_en;
      bus_rdata[RST_EN_BIT]   = cfg.rst_en;
      bus_rdata[RST_FLAG_BIT] = rst_flag;
    end
  end

  assign irq = irq_flag && cfg.irq_en;
endmodule

// File: rtl/wdog_dual_chk.sv
module wdog_dual_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_wr,
  input logic             clr_irq_bit,
  input logic             clr_rst_bit,
  input logic             irq_flag,
  input logic             rst_flag,
  input logic             rst_req,
  input logic             tmr_en,
  input logic             feed_clr,
  input logic [CNT_W-1:0] cnt
);
  assert_req_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  assert_req_flagged_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> rst_flag);

  assert_hold_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!tmr_en && !feed_clr) |=> $stable(cnt));

  assert_feed_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    feed_clr |=> (cnt == '0));

  assert_irq_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !(cfg_wr && clr_irq_bit)) |=> irq_flag);

  assert_rst_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_flag && !(cfg_wr && clr_rst_bit)) |=> rst_flag);
endmodule

bind wdog_dual wdog_dual_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_wr      (cfg_wr),
  .clr_irq_bit (bus_wdata[9]),
  .clr_rst_bit (bus_wdata[31]),
  .irq_flag    (irq_flag),
  .rst_flag    (rst_flag),
  .rst_req     (rst_req),
  .tmr_en      (tmr_en),
  .feed_clr    (feed_clr),
  .cnt         (cnt)
);

// File: tb/wdog_dual_bench.sv
`timescale 1ns/1ps
module wdog_dual_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        irq, rst_req;

  int nchk = 0;
  int nerr = 0;
  int cyc  = 0;
  int irq_q[$];
  int rst_q[$];
  logic irq_prev = 1'b0;
  bit   done = 1'b0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdog_dual #(.CNT_W(32), .SIM_SHIFT(12), .ADDR_W(2)) u_wdog_dual (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .rst_req(rst_req)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: compare observed events against the scoreboard queues
  always @(negedge clk) begin
    if (rst_n) begin
      if (rst_req) begin
        if (rst_q.size() == 0) check("R4/R7/R9 unexpected rst_req", cyc, 32'hFFFF_FFFF);
        else check("R4 rst_req edge", cyc, rst_q.pop_front());
      end
      if (irq && !irq_prev) begin
        if (irq_q.size() == 0) check("R3/R7/R8 unexpected irq", cyc, 32'hFFFF_FFFF);
        else check("R3 irq edge", cyc, irq_q.pop_front());
      end
      irq_prev = irq;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d, output int edge_no);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    edge_no = cyc + 1;
    @(posedge clk); #1;
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_valid = 1'b1; bus_write = 1'b0;
    #1 d = bus_rdata;
    bus_valid = 1'b0;
  endtask

  task automatic feed(output int edge_no);
    int tmp;
    wr(2'd1, 32'hA5, tmp);
    wr(2'd1, 32'h5A, edge_no);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    int e;
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(2'd0, d);   check("R1 cfg word", d, 32'h0);
    check("R1 irq", {31'd0, irq}, 32'd0);
    check("R1 rst_req", {31'd0, rst_req}, 32'd0);

    // R2 R3 R4: irq code 15 (16 edges), reset code 14 (32 edges)
    wr(2'd0, 32'h0000_0DEF, e);
    irq_q.push_back(e + 16); rst_q.push_back(e + 32);
    idle(45);
    rd(2'd0, d);   check("R2 R10 word after events", d, 32'h8000_0FEF);
    check("R3 irq level", {31'd0, irq}, 32'd1);

    // R10 write-one clear
    wr(2'd0, 32'h8000_0FEF, e);
    rd(2'd0, d);   check("R10 flags cleared", d, 32'h0000_0DEF);
    check("R10 irq low", {31'd0, irq}, 32'd0);

    // R5 regular servicing keeps events away
    for (int i = 0; i < 8; i++) begin
      feed(e);
      idle(10);
    end
    irq_q.push_back(e + 16); rst_q.push_back(e + 32);
    idle(40);
    rd(2'd0, d);   check("R5 flags after lapse", d, 32'h8000_0FEF);

    // R6 broken sequence does not clear
    wr(2'd0, 32'h8000_0FEF, e);
    feed(e);
    irq_q.push_back(e + 16); rst_q.push_back(e + 32);
    idle(3);
    wr(2'd1, 32'hA5, e);
    wr(2'd1, 32'h33, e);
    wr(2'd1, 32'h5A, e);
    idle(40);
    check("R6 irq queue drained", irq_q.size(), 32'd0);
    check("R6 rst queue drained", rst_q.size(), 32'd0);

    // R7 disable holds count (count = 1 after the disabling edge)
    wr(2'd0, 32'h8000_0FEF, e);
    feed(e);
    wr(2'd0, 32'h0000_0CEF, e);
    idle(100);
    rd(2'd0, d);   check("R7 no flags while off", d, 32'h0000_0CEF);
    wr(2'd0, 32'h0000_0DEF, e);
    irq_q.push_back(e + 15); rst_q.push_back(e + 31);
    idle(40);

    // R8 R9 enables off: flags set, outputs quiet
    wr(2'd0, 32'h8000_03EF, e);
    feed(e);
    idle(40);
    rd(2'd0, d);   check("R8 R9 flags set, enables off", d, 32'h8000_03EF);
    check("R8 irq gated", {31'd0, irq}, 32'd0);

    // R3 R4 independent: reset code 15 (16), irq code 13 (64)
    wr(2'd0, 32'h8000_0FFD, e);
    feed(e);
    rst_q.push_back(e + 16); irq_q.push_back(e + 64);
    idle(70);
    rd(2'd0, d);   check("R3 R4 swapped order word", d, 32'h8000_0FFD);

    check("R3 irq queue empty", irq_q.size(), 32'd0);
    check("R4 rst queue empty", rst_q.size(), 32'd0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule